// File: doc/BRIEF.md
# Multiplexed ADC Channel Scan Sequencer

This block decides, for every conversion of a multi-channel analog acquisition, which input the front-end multiplexer selects and which gain code goes with it. A convert trigger (one-cycle pulse) asks for a conversion. The sequencer answers one cycle later with a conversion-start strobe, the multiplexer address for that conversion, the gain code and an end-of-scan flag that marks the last channel of the list.

Four modes exist. In single-channel mode every conversion uses the programmed channel. In scan-up mode the list runs from channel 0 up to the programmed channel. In scan-down mode it runs from the programmed channel down to 0. Single-channel mode and both scan modes can run continuously or in interval mode. In interval mode each burst of N conversions waits for a scan-start pulse. Scanning is switched on by a second configuration write that repeats the channel and gain already held. The burst length N is staged and only becomes active on a load strobe.

Top module: `adc_scan_seq`

## Requirements
- R1: After a synchronous active-low reset, conv_start, scan_end, mux_chan and gain_out are all 0, the active burst length is 1 and the mode is continuous single-channel on channel 0.
- R2: Every accepted convert trigger produces conv_start high for exactly the cycle after the trigger's clock edge. In single-channel mode every conversion uses the programmed channel and raises scan_end.
- R3: In single-channel mode with cfg_diff=1, mux_chan is the programmed channel shifted left by one bit, modulo NUM_CH (valid for channels below NUM_CH/2). cfg_diff has no effect in either scan mode.
- R4: Scan-up mode (cfg_down=0) converts channels 0,1,…,C in order, where C is the programmed channel. scan_end is 1 only on C, and the list then restarts at 0.
- R5: Scan-down mode (cfg_down=1) converts C, C-1, …, 0. scan_end is 1 only on channel 0, and the list then restarts at C.
- R6: A configuration write with cfg_scan=1 enables scanning only when its channel and gain fields equal the values already held. Otherwise the write loads channel and gain and leaves scanning off, so the block runs in single-channel mode.
- R7: A write to the staging register (icnt_wr) leaves the active burst length unchanged. Only icnt_load copies the staged value into the active length. An active length of 0 behaves as 1.
- R8: With cfg_ivl=1 the block waits after a configuration write, after a load and after each burst. Convert triggers are ignored while it waits. A scan-start pulse releases a burst of exactly N accepted conversions, and that burst begins at the start channel (0 for scan-up, otherwise the programmed channel).
- R9: A scan-start pulse has no effect in continuous mode (cfg_ivl=0), and none while an interval burst is still running.
- R10: gain_out shows the programmed gain code on every conversion, because all entries in a scan share one gain.
- R11: A configuration write or a length load restarts the sequence at the start channel. A convert trigger in the same cycle as either one is dropped.
- R12: Between accepted conversions, mux_chan and gain_out hold their values, and conv_start and scan_end stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | CH_W | Programmed channel (last of an up list, first of a down list) |
| cfg_gain | input | GAIN_W | Gain code shared by all conversions |
| cfg_scan | input | 1 | Scan enable (honoured on a repeated write only) |
| cfg_down | input | 1 | Scan direction, 1 = downward |
| cfg_ivl | input | 1 | Interval mode, 1 = bursts gated by scan start |
| cfg_diff | input | 1 | Differential input select |
| icnt_wr | input | 1 | Stage burst length strobe |
| icnt_val | input | LEN_W | Burst length to stage |
| icnt_load | input | 1 | Copy staged length into active length |
| conv_trig | input | 1 | Convert trigger pulse |
| scan_trig | input | 1 | Scan-start trigger pulse |
| mux_chan | output | CH_W | Multiplexer address of the current conversion |
| gain_out | output | GAIN_W | Gain code of the current conversion |
| conv_start | output | 1 | Conversion-start strobe |
| scan_end | output | 1 | Last channel of the list converted |

## Verification
On every cycle, the assertions check the following:
- the strobe only follows a convert trigger;
- the address and gain hold when no conversion occurs;
- end-of-scan never appears without a strobe;
- the scan-up pointer never passes the programmed channel;
- the active length only changes on a load;
- a waiting interval scan stays waiting until a scan-start pulse or a restart.

Some behaviours can only be shown by the bench's scenarios, which compare against expected lists:
- the actual channel orders in each mode;
- differential doubling and the cases where it is ignored;
- the second-write rule;
- exact burst lengths;
- the dropping of triggers in the cycle of a restart.

// File: rtl/scan_seq_pkg.sv
// Shared definitions for the ADC channel scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_seq_pkg;

    // Channel-order modes. The encoding is internal to the block.
    typedef enum logic [1:0] {
        SEQ_SINGLE     = 2'd0,
        SEQ_SINGLE_IVL = 2'd1,
        SEQ_UP         = 2'd2,
        SEQ_DOWN       = 2'd3
    } seq_mode_e;

    // True for either single-channel mode.
    function automatic logic mode_is_single(seq_mode_e m);
        return (m == SEQ_SINGLE) || (m == SEQ_SINGLE_IVL);
    endfunction

endpackage

// File: rtl/scan_cfg_regs.sv
// Configuration holding registers for the scan sequencer.
// Holds channel, gain, mode, interval and differential settings and the
// staged and active burst lengths. Scan enable is honoured only on a
// write that repeats the held channel and gain.
// Assumes: strobes are single-cycle and come from one register port.
module scan_cfg_regs
    import scan_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int GAIN_W = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CH_W-1:0]   chan_in,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              scan_in,
    input  logic              down_in,
    input  logic              ivl_in,
    input  logic              diff_in,
    input  logic              icnt_wr,
    input  logic [LEN_W-1:0]  icnt_in,
    input  logic              icnt_load,
    output logic [CH_W-1:0]   chan_q,
    output logic [GAIN_W-1:0] gain_q,
    output seq_mode_e         mode_q,
    output logic              ivl_q,
    output logic              diff_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [CH_W-1:0]   chan_d,
    output seq_mode_e         mode_d,
    output logic              ivl_d,
    output logic              restart
);

    logic             scan_q;
    logic             down_q;
    logic             scan_d;
    logic             down_d;
    logic [LEN_W-1:0] stage_q;

    // Next-state values of the channel/mode fields seen by the pointer.
    always_comb begin
        chan_d = cfg_wr ? chan_in : chan_q;
        down_d = cfg_wr ? down_in : down_q;
        ivl_d  = cfg_wr ? ivl_in  : ivl_q;
        scan_d = cfg_wr ? (scan_in && (chan_in == chan_q) && (gain_in == gain_q))
                        : scan_q;
        if (scan_d)
            mode_d = down_d ? SEQ_DOWN : SEQ_UP;
        else
            mode_d = ivl_d ? SEQ_SINGLE_IVL : SEQ_SINGLE;
        restart = cfg_wr || icnt_load;
    end

    // Configuration register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            gain_q <= '0;
            scan_q <= 1'b0;
            down_q <= 1'b0;
            ivl_q  <= 1'b0;
            diff_q <= 1'b0;
            mode_q <= SEQ_SINGLE;
        end else begin
            if (cfg_wr) begin
                gain_q <= gain_in;
                diff_q <= diff_in;
            end
            chan_q <= chan_d;
            scan_q <= scan_d;
            down_q <= down_d;
            ivl_q  <= ivl_d;
            mode_q <= mode_d;
        end
    end

    // Staged and active burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= LEN_W'(1);
            len_q   <= LEN_W'(1);
        end else begin
            if (icnt_wr)
                stage_q <= icnt_in;
            if (icnt_load)
                len_q <= stage_q;
        end
    end

    // R7: the active length moves only on a load strobe.
    p_len_load_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !icnt_load |=> $stable(len_q))
        else $error("active length changed without load");

    // R6: scanning switches on only with channel and gain unchanged.
    p_scan_second_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_q) |-> (chan_q == $past(chan_q)) && (gain_q == $past(gain_q)))
        else $error("scan enabled with new channel or gain");

endmodule

// File: rtl/scan_ptr.sv
// Channel pointer and interval gate of the scan sequencer.
// Steps through the channel list on each accepted convert trigger, marks
// the last entry, and counts bursts in interval mode.
// Assumes: configuration inputs are registered; the *_d inputs are their
// next-state values, used when a restart reloads the pointer.
module scan_ptr
    import scan_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_trig,
    input  logic             scan_trig,
    input  logic [CH_W-1:0]  chan_q,
    input  seq_mode_e        mode_q,
    input  logic             ivl_q,
    input  logic [LEN_W-1:0] len_q,
    input  logic [CH_W-1:0]  chan_d,
    input  seq_mode_e        mode_d,
    input  logic             ivl_d,
    input  logic             restart,
    output logic             accept,
    output logic [CH_W-1:0]  ptr_q,
    output logic             last
);

    logic             wait_q;
    logic [LEN_W-1:0] burst_q;
    logic [LEN_W-1:0] len_eff;
    logic [CH_W-1:0]  ptr_nx;
    logic             burst_done;
    logic             arm;

    // Accept decision, end-of-list detection and next pointer.
    always_comb begin
        len_eff    = (len_q == '0) ? LEN_W'(1) : len_q;
        accept     = conv_trig && !wait_q && !restart;
        arm        = scan_trig && wait_q && ivl_q && !restart;
        burst_done = (burst_q == len_eff - LEN_W'(1));
        case (mode_q)
            SEQ_UP:   last = (ptr_q == chan_q);
            SEQ_DOWN: last = (ptr_q == '0);
            default:  last = 1'b1;
        endcase
        case (mode_q)
            SEQ_UP:   ptr_nx = last ? '0 : ptr_q + CH_W'(1);
            SEQ_DOWN: ptr_nx = last ? chan_q : ptr_q - CH_W'(1);
            default:  ptr_nx = chan_q;
        endcase
    end

    // Pointer, wait flag and burst counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            wait_q  <= 1'b0;
            burst_q <= '0;
        end else if (restart) begin
            ptr_q   <= (mode_d == SEQ_UP) ? '0 : chan_d;
            wait_q  <= ivl_d;
            burst_q <= '0;
        end else if (arm) begin
            ptr_q   <= (mode_q == SEQ_UP) ? '0 : chan_q;
            wait_q  <= 1'b0;
            burst_q <= '0;
        end else if (accept) begin
            ptr_q <= ptr_nx;
            if (ivl_q) begin
                if (burst_done) begin
                    wait_q  <= 1'b1;
                    burst_q <= '0;
                end else begin
                    burst_q <= burst_q + LEN_W'(1);
                end
            end
        end
    end

    // R4: an upward list never passes the programmed channel.
    p_up_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEQ_UP) |-> (ptr_q <= chan_q))
        else $error("upward pointer beyond programmed channel");

    // R8: a waiting interval scan stays waiting until armed or restarted.
    p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !scan_trig && !restart) |=> wait_q)
        else $error("wait released without scan start");

endmodule

// File: rtl/scan_out.sv
// Output stage of the scan sequencer: registers the strobe, the
// multiplexer address (doubled for differential single-channel use),
// the gain and the end-of-scan flag.
// Assumes: accept is high for one cycle per conversion.
module scan_out
    import scan_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CH_W-1:0]   ptr,
    input  logic              last,
    input  seq_mode_e         mode_q,
    input  logic              diff_q,
    input  logic [GAIN_W-1:0] gain_q,
    output logic [CH_W-1:0]   mux_chan,
    output logic [GAIN_W-1:0] gain_out,
    output logic              conv_start,
    output logic              scan_end
);

    logic [CH_W-1:0] addr;

    // Physical address: doubled only for differential single-channel use.
    generate
        if (CH_W > 1) begin : g_dbl
            always_comb begin
                if (diff_q && mode_is_single(mode_q))
                    addr = {ptr[CH_W-2:0], 1'b0};
                else
                    addr = ptr;
            end
        end else begin : g_nodbl
            always_comb addr = (diff_q && mode_is_single(mode_q)) ? '0 : ptr;
        end
    endgenerate

    // Output registers, updated only on an accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_chan   <= '0;
            gain_out   <= '0;
            conv_start <= 1'b0;
            scan_end   <= 1'b0;
        end else begin
            conv_start <= accept;
            scan_end   <= accept && last;
            if (accept) begin
                mux_chan <= addr;
                gain_out <= gain_q;
            end
        end
    end

    // R12: address and gain hold between conversions.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(mux_chan) && $stable(gain_out))
        else $error("outputs moved without conversion");

    // R4: end-of-scan is only ever seen with a strobe.
    p_eos_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end |-> conv_start)
        else $error("end-of-scan without strobe");

endmodule

// File: rtl/adc_scan_seq.sv
// Top of the ADC channel scan sequencer. Joins the configuration
// registers, the channel pointer with its interval gate, and the output
// stage.
// Assumes: triggers and strobes are single-cycle pulses in the clk domain.
module adc_scan_seq
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int GAIN_W = 4,
    parameter int LEN_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              cfg_scan,
    input  logic              cfg_down,
    input  logic              cfg_ivl,
    input  logic              cfg_diff,
    input  logic              icnt_wr,
    input  logic [LEN_W-1:0]  icnt_val,
    input  logic              icnt_load,
    input  logic              conv_trig,
    input  logic              scan_trig,
    output logic [CH_W-1:0]   mux_chan,
    output logic [GAIN_W-1:0] gain_out,
    output logic              conv_start,
    output logic              scan_end
);

    logic [CH_W-1:0]   chan_q;
    logic [CH_W-1:0]   chan_d;
    logic [GAIN_W-1:0] gain_q;
    seq_mode_e         mode_q;
    seq_mode_e         mode_d;
    logic              ivl_q;
    logic              ivl_d;
    logic              diff_q;
    logic [LEN_W-1:0]  len_q;
    logic              restart;
    logic              accept;
    logic [CH_W-1:0]   ptr_q;
    logic              last;

    scan_cfg_regs #(.CH_W(CH_W), .GAIN_W(GAIN_W), .LEN_W(LEN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .chan_in(cfg_chan), .gain_in(cfg_gain), .scan_in(cfg_scan),
        .down_in(cfg_down), .ivl_in(cfg_ivl), .diff_in(cfg_diff),
        .icnt_wr(icnt_wr), .icnt_in(icnt_val), .icnt_load(icnt_load),
        .chan_q(chan_q), .gain_q(gain_q), .mode_q(mode_q), .ivl_q(ivl_q),
        .diff_q(diff_q), .len_q(len_q), .chan_d(chan_d), .mode_d(mode_d),
        .ivl_d(ivl_d), .restart(restart)
    );

    scan_ptr #(.CH_W(CH_W), .LEN_W(LEN_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .conv_trig(conv_trig), .scan_trig(scan_trig),
        .chan_q(chan_q), .mode_q(mode_q), .ivl_q(ivl_q), .len_q(len_q),
        .chan_d(chan_d), .mode_d(mode_d), .ivl_d(ivl_d), .restart(restart),
        .accept(accept), .ptr_q(ptr_q), .last(last)
    );

    scan_out #(.CH_W(CH_W), .GAIN_W(GAIN_W)) u_out (
        .clk(clk), .rst_n(rst_n), .accept(accept), .ptr(ptr_q), .last(last),
        .mode_q(mode_q), .diff_q(diff_q), .gain_q(gain_q),
        .mux_chan(mux_chan), .gain_out(gain_out), .conv_start(conv_start),
        .scan_end(scan_end)
    );

    // R2: a strobe always follows a convert trigger.
    p_strobe_from_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(conv_trig))
        else $error("strobe without trigger");

    // R11: a trigger coinciding with a configuration write is dropped.
    p_drop_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_trig && cfg_wr) |=> !conv_start)
        else $error("trigger accepted during configuration write");

endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

    localparam int NUM_CH = 8;
    localparam int CH_W   = 3;
    localparam int GAIN_W = 4;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [CH_W-1:0]   cfg_chan = '0;
    logic [GAIN_W-1:0] cfg_gain = '0;
    logic              cfg_scan = 1'b0;
    logic              cfg_down = 1'b0;
    logic              cfg_ivl = 1'b0;
    logic              cfg_diff = 1'b0;
    logic              icnt_wr = 1'b0;
    logic [LEN_W-1:0]  icnt_val = '0;
    logic              icnt_load = 1'b0;
    logic              conv_trig = 1'b0;
    logic              scan_trig = 1'b0;
    logic [CH_W-1:0]   mux_chan;
    logic [GAIN_W-1:0] gain_out;
    logic              conv_start;
    logic              scan_end;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    adc_scan_seq #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
        .cfg_gain(cfg_gain), .cfg_scan(cfg_scan), .cfg_down(cfg_down),
        .cfg_ivl(cfg_ivl), .cfg_diff(cfg_diff), .icnt_wr(icnt_wr),
        .icnt_val(icnt_val), .icnt_load(icnt_load), .conv_trig(conv_trig),
        .scan_trig(scan_trig), .mux_chan(mux_chan), .gain_out(gain_out),
        .conv_start(conv_start), .scan_end(scan_end)
    );

    // Row: chan(3) gain(4) down scan diff | exp0..exp3 (3 each) | eos mask(4, bit i = conv i)
    localparam int ROWS = 8;
    localparam logic [25:0] VEC [ROWS] = '{
        {3'd5, 4'd3,  1'b0, 1'b0, 1'b0, 3'd5, 3'd5, 3'd5, 3'd5, 4'b1111}, // R2
        {3'd3, 4'd7,  1'b0, 1'b0, 1'b1, 3'd6, 3'd6, 3'd6, 3'd6, 4'b1111}, // R3
        {3'd2, 4'd1,  1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 3'd2, 3'd0, 4'b0100}, // R4
        {3'd2, 4'd9,  1'b1, 1'b1, 1'b0, 3'd2, 3'd1, 3'd0, 3'd2, 4'b0100}, // R5
        {3'd3, 4'd2,  1'b0, 1'b1, 1'b1, 3'd0, 3'd1, 3'd2, 3'd3, 4'b1000}, // R3 no doubling in scan
        {3'd0, 4'd15, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 4'b1111}, // R5 one-entry list
        {3'd1, 4'd0,  1'b0, 1'b0, 1'b1, 3'd2, 3'd2, 3'd2, 3'd2, 4'b1111}, // R3
        {3'd7, 4'd4,  1'b0, 1'b1, 1'b0, 3'd0, 3'd1, 3'd2, 3'd3, 4'b0000}  // R4
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic write_cfg(input int ch, input int g, input bit sc,
                             input bit dn, input bit iv, input bit df);
        @(negedge clk);
        cfg_chan = CH_W'(ch); cfg_gain = GAIN_W'(g); cfg_scan = sc;
        cfg_down = dn; cfg_ivl = iv; cfg_diff = df; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Two writes: the second repeats channel and gain so scan takes effect.
    task automatic setup(input int ch, input int g, input bit sc,
                         input bit dn, input bit iv, input bit df);
        write_cfg(ch, g, sc, dn, iv, df);
        if (sc) write_cfg(ch, g, sc, dn, iv, df);
    endtask

    // Pulse a convert trigger; outputs are sampled at the next falling edge.
    task automatic conv();
        @(negedge clk); conv_trig = 1'b1;
        @(negedge clk); conv_trig = 1'b0;
    endtask

    task automatic scan_pulse();
        @(negedge clk); scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
    endtask

    task automatic load_len(input int n);
        @(negedge clk); icnt_wr = 1'b1; icnt_val = LEN_W'(n);
        @(negedge clk); icnt_wr = 1'b0; icnt_load = 1'b1;
        @(negedge clk); icnt_load = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        logic [CH_W-1:0] held;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 conv_start", conv_start, 0);
        check("R1 scan_end", scan_end, 0);
        check("R1 mux_chan", mux_chan, 0);
        check("R1 gain_out", gain_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        conv();
        check("R1 default single ch0", mux_chan, 0);
        check("R1 default strobe", conv_start, 1);

        // Table walk in continuous mode
        for (int r = 0; r < ROWS; r++) begin
            logic [25:0] v;
            v = VEC[r];
            setup(int'(v[25:23]), int'(v[22:19]), v[17], v[18], 1'b0, v[16]);
            for (int k = 0; k < 4; k++) begin
                conv();
                check("R2 strobe", conv_start, 1);
                check("R4/R5/R3 channel", mux_chan, int'(v[15 - 3*k -: 3]));
                check("R10 gain", gain_out, int'(v[22:19]));
                check("R4/R5 end-of-scan", scan_end, int'(v[k]));
            end
            // R12: quiet cycle holds outputs
            @(negedge clk);
            check("R12 strobe low", conv_start, 0);
            check("R12 eos low", scan_end, 0);
            check("R12 mux hold", mux_chan, int'(v[6:4]));
        end

        // R6: scan enable with a changed channel is not honoured
        write_cfg(1, 0, 0, 0, 0, 0);
        write_cfg(4, 0, 1, 0, 0, 0);
        conv(); check("R6 single ch", mux_chan, 4);
        conv(); check("R6 still single", mux_chan, 4);
        check("R6 eos each", scan_end, 1);
        write_cfg(4, 0, 1, 0, 0, 0);
        conv(); check("R6 scan now on", mux_chan, 0);
        conv(); check("R6 scan step", mux_chan, 1);

        // R9: scan start ignored in continuous mode
        scan_pulse();
        conv(); check("R9 no restart continuous", mux_chan, 2);

        // R11: config write restarts; simultaneous trigger dropped
        @(negedge clk);
        cfg_chan = 3'd4; cfg_gain = 4'd0; cfg_scan = 1'b1; cfg_down = 1'b1;
        cfg_ivl = 1'b0; cfg_diff = 1'b0; cfg_wr = 1'b1; conv_trig = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; conv_trig = 1'b0;
        check("R11 trigger dropped", conv_start, 0);
        conv(); check("R11 restart at start", mux_chan, 4);
        conv(); check("R11 next", mux_chan, 3);

        // R8: interval single-channel, default length 1
        setup(6, 5, 0, 0, 1, 0);
        held = mux_chan;
        conv(); check("R8 ignored while waiting", conv_start, 0);
        check("R8 mux unchanged", mux_chan, int'(held));
        scan_pulse();
        conv(); check("R8 burst conv", conv_start, 1);
        check("R8 burst channel", mux_chan, 6);
        conv(); check("R8 burst of 1 ended", conv_start, 0);

        // R7: staged length not active until load; then active
        @(negedge clk); icnt_wr = 1'b1; icnt_val = 8'd3;
        @(negedge clk); icnt_wr = 1'b0;
        scan_pulse();
        conv(); check("R7 len still 1 first", conv_start, 1);
        conv(); check("R7 len still 1 second", conv_start, 0);
        @(negedge clk); icnt_load = 1'b1;
        @(negedge clk); icnt_load = 1'b0;
        scan_pulse();
        n = 0;
        conv(); n += int'(conv_start);
        scan_pulse();   // R9: ignored during a running burst
        for (int k = 0; k < 3; k++) begin conv(); n += int'(conv_start); end
        check("R7 loaded length 3", n, 3);
        check("R9 burst not extended", conv_start, 0);

        // R8: interval scan-up, bursts restart at channel 0
        load_len(2);
        setup(3, 2, 1, 0, 1, 0);
        scan_pulse();
        conv(); check("R8 up first", mux_chan, 0);
        conv(); check("R8 up second", mux_chan, 1);
        conv(); check("R8 waits after N", conv_start, 0);
        scan_pulse();
        conv(); check("R8 burst restarts at 0", mux_chan, 0);

        // R7: length 0 acts as 1
        load_len(0);
        scan_pulse();
        conv(); check("R7 zero first", conv_start, 1);
        conv(); check("R7 zero acts as 1", conv_start, 0);

        finish_up();
    end

endmodule